// File: doc/BRIEF.md
# Gated Multi-Source Frequency Counter

This block measures the rate of one of three internal clock-like signals: an intermediate-frequency signal, a prescaler output and a calibration oscillator. A control register write sets a self-clearing start bit. The block then opens a gate window that the reference clock times. During the window it counts the edges of the chosen source, and it finally presents the 16-bit count as two bytes. Software divides the count by the gate length in milliseconds to get the frequency in kHz. That conversion is not part of this block.

The edges are counted in the domain of the selected source. The gate-enable level crosses into that domain through a synchronizer. The running count is kept in Gray code and crosses back into the reference domain through a second synchronizer. After the gate closes, a fixed drain interval lets the last count settle before it is captured. Each of the four gate lengths is a parameter in reference cycles, so a bench can run on a shortened time scale. The drain interval must cover the two synchronizer paths, which is why a slow source needs a longer drain.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, trig_bit, busy and done are 0, and both count bytes read 0.
- R2: A cycle with trig_we=1 and trig_wdata=1 while the block is idle makes trig_bit read 1 for exactly one cycle. It then returns to 0 without any further write. A write of trig_wdata=0 leaves trig_bit at 0 and does not change done or the count.
- R3: Source code 1 or 7 selects src_if, code 2 selects src_presc, and code 4 or 5 selects src_f0. The result is the number of edges of that input within the gate, to within ±3.
- R4: Source codes 0, 3 and 6 are unused. A trigger with such a code never raises busy. One cycle after trig_bit it sets done=1 and a count of 0.
- R5: Gate code 0, 1, 2 or 3 selects a gate of GATE_CYC0, GATE_CYC1, GATE_CYC2 or GATE_CYC3 reference cycles. busy stays high for exactly that gate length plus DRAIN_CYC cycles.
- R6: The count saturates at 0xFFFF and does not wrap.
- R7: cnt_lo carries count bits 7:0 and cnt_hi carries count bits 15:8. Both hold their value until the next measurement completes, including the whole time the next measurement is running.
- R8: A trigger write while busy is high is ignored. trig_bit stays 0 and the running measurement keeps its length.
- R9: done rises when a result is captured and stays high until the next accepted trigger. busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that times the gate |
| ref_rst_n | input | 1 | Active-low asynchronous reset for both domains |
| src_if | input | 1 | Intermediate-frequency source signal |
| src_presc | input | 1 | Prescaler output source signal |
| src_f0 | input | 1 | Calibration oscillator source signal |
| src_code | input | 3 | Source select code |
| gate_code | input | 2 | Gate length select code |
| trig_we | input | 1 | Write strobe of the start bit |
| trig_wdata | input | 1 | Value written to the start bit |
| trig_bit | output | 1 | Read-back of the self-clearing start bit |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | A result is valid |
| cnt_lo | output | 8 | Count bits 7:0 |
| cnt_hi | output | 8 | Count bits 15:8 |

## Verification
The assertions check the following on every cycle:
- the start bit clears one cycle after it is set;
- a write while busy is dropped;
- busy and done are exclusive;
- an unused code completes at once with a zero count;
- the result stays stable while the gate is open;
- the gate timer stays inside the selected window;
- in the source domain, a saturated count holds, and the Gray count moves by at most one bit per edge except at the clear.

Only the bench scenarios can show the rest. These are the mapping of every source code to the right input, the agreement of the count with the source-to-reference clock ratio over all gate codes, the exact busy length, saturation on a long gate, and the byte split of the result.

// File: rtl/freq_cnt_pkg.sv
`timescale 1ns/1ps
package freq_cnt_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_IF   = 2'd1,
      SRC_PRE  = 2'd2,
      SRC_F0   = 2'd3
   } fc_src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GATE  = 2'd1,
      ST_DRAIN = 2'd2
   } fc_state_e;

   // Several codes share one source; the remaining codes are unused.
   function automatic fc_src_e fc_decode(input logic [2:0] code);
      case (code)
         3'd1, 3'd7: fc_decode = SRC_IF;
         3'd2:       fc_decode = SRC_PRE;
         3'd4, 3'd5: fc_decode = SRC_F0;
         default:    fc_decode = SRC_NONE;
      endcase
   endfunction

endpackage

// File: rtl/fc_sync.sv
`timescale 1ns/1ps
module fc_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("fc_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/fc_clk_select.sv
`timescale 1ns/1ps
module fc_clk_select
   import freq_cnt_pkg::*;
(
   input  fc_src_e sel,
   input  logic    src_if,
   input  logic    src_presc,
   input  logic    src_f0,
   output logic    sclk
);
   always_comb begin
      case (sel)
         SRC_IF:  sclk = src_if;
         SRC_PRE: sclk = src_presc;
         SRC_F0:  sclk = src_f0;
         default: sclk = 1'b0;
      endcase
   end
endmodule

// File: rtl/fc_src_counter.sv
`timescale 1ns/1ps
module fc_src_counter #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             sclk,
   input  logic             rst_n,
   input  logic             gate_async,
   output logic [CNT_W-1:0] gray_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic             gate_s;
   logic             gate_d;
   logic             gate_rise;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nxt;

   fc_sync #(.W(1), .STAGES(SYNC_STAGES)) u_gate_sync (
      .clk   (sclk),
      .rst_n (rst_n),
      .d     (gate_async),
      .q     (gate_s)
   );

   assign gate_rise = gate_s & ~gate_d;

   always_comb begin
      cnt_nxt = cnt;
      if (gate_rise)                     cnt_nxt = '0;
      else if (gate_s && cnt != CNT_MAX) cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         cnt    <= '0;
         gray_q <= '0;
      end else begin
         gate_d <= gate_s;
         cnt    <= cnt_nxt;
         gray_q <= cnt_nxt ^ (cnt_nxt >> 1);
      end
   end

   // R6
   sat_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      (cnt == CNT_MAX && !gate_rise) |=> (cnt == CNT_MAX));

   // R3
   gray_step_chk: assert property (@(posedge sclk) disable iff (!rst_n)
      !gate_rise |=> ($countones(gray_q ^ $past(gray_q)) <= 1));
endmodule

// File: rtl/freq_gate_counter.sv
`timescale 1ns/1ps
module freq_gate_counter
   import freq_cnt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int REF_PER_MS  = 7200,
   parameter int GATE_CYC0   = 4  * REF_PER_MS,
   parameter int GATE_CYC1   = 8  * REF_PER_MS,
   parameter int GATE_CYC2   = 32 * REF_PER_MS,
   parameter int GATE_CYC3   = 64 * REF_PER_MS,
   parameter int DRAIN_CYC   = 8
) (
   input  logic       ref_clk,
   input  logic       ref_rst_n,
   input  logic       src_if,
   input  logic       src_presc,
   input  logic       src_f0,
   input  logic [2:0] src_code,
   input  logic [1:0] gate_code,
   input  logic       trig_we,
   input  logic       trig_wdata,
   output logic       trig_bit,
   output logic       busy,
   output logic       done,
   output logic [7:0] cnt_lo,
   output logic [7:0] cnt_hi
);
   localparam int MAX_GATE = (GATE_CYC3 > GATE_CYC2) ? GATE_CYC3 : GATE_CYC2;
   localparam int MAX_LEN  = (MAX_GATE > DRAIN_CYC) ? MAX_GATE : DRAIN_CYC;
   localparam int TMR_W    = $clog2(MAX_LEN + 1);

   if (CNT_W != 16) begin : g_bad_cnt
      $error("freq_gate_counter: result is two bytes, CNT_W must be 16");
   end
   if (GATE_CYC0 < 1 || GATE_CYC1 < GATE_CYC0 || GATE_CYC2 < GATE_CYC1 || GATE_CYC3 < GATE_CYC2) begin : g_bad_gate
      $error("freq_gate_counter: gate lengths must be positive and ascending");
   end
   if (DRAIN_CYC < 2 * SYNC_STAGES + 2) begin : g_bad_drain
      $error("freq_gate_counter: DRAIN_CYC too short for the synchronizers");
   end

   fc_state_e        state;
   fc_src_e          src_q;
   fc_src_e          src_dec;
   logic [TMR_W-1:0] tmr;
   logic [TMR_W-1:0] gate_len_q;
   logic [TMR_W-1:0] gate_len_sel;
   logic             gate_q;
   logic             sclk;
   logic [CNT_W-1:0] gray_src;
   logic [CNT_W-1:0] gray_ref;
   logic [CNT_W-1:0] bin_ref;
   logic [CNT_W-1:0] result;

   assign src_dec = fc_decode(src_code);

   always_comb begin
      case (gate_code)
         2'd0:    gate_len_sel = TMR_W'(GATE_CYC0);
         2'd1:    gate_len_sel = TMR_W'(GATE_CYC1);
         2'd2:    gate_len_sel = TMR_W'(GATE_CYC2);
         default: gate_len_sel = TMR_W'(GATE_CYC3);
      endcase
   end

   fc_clk_select u_sel (
      .sel       (src_q),
      .src_if    (src_if),
      .src_presc (src_presc),
      .src_f0    (src_f0),
      .sclk      (sclk)
   );

   fc_src_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
      .sclk       (sclk),
      .rst_n      (ref_rst_n),
      .gate_async (gate_q),
      .gray_q     (gray_src)
   );

   fc_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_res_sync (
      .clk   (ref_clk),
      .rst_n (ref_rst_n),
      .d     (gray_src),
      .q     (gray_ref)
   );

   for (genvar gi = 0; gi < CNT_W; gi++) begin : g_g2b
      assign bin_ref[gi] = ^gray_ref[CNT_W-1:gi];
   end

   always_ff @(posedge ref_clk or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         state      <= ST_IDLE;
         src_q      <= SRC_NONE;
         tmr        <= '0;
         gate_len_q <= '0;
         gate_q     <= 1'b0;
         trig_bit   <= 1'b0;
         done       <= 1'b0;
         result     <= '0;
      end else begin
         trig_bit <= trig_we & trig_wdata & (state == ST_IDLE);
         case (state)
            ST_IDLE: begin
               if (trig_bit) begin
                  if (src_dec == SRC_NONE) begin
                     result <= '0;
                     done   <= 1'b1;
                  end else begin
                     src_q      <= src_dec;
                     gate_len_q <= gate_len_sel;
                     tmr        <= '0;
                     gate_q     <= 1'b1;
                     done       <= 1'b0;
                     state      <= ST_GATE;
                  end
               end
            end
            ST_GATE: begin
               if (tmr == gate_len_q - 1'b1) begin
                  tmr    <= '0;
                  gate_q <= 1'b0;
                  state  <= ST_DRAIN;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (tmr == TMR_W'(DRAIN_CYC - 1)) begin
                  tmr    <= '0;
                  result <= bin_ref;
                  done   <= 1'b1;
                  state  <= ST_IDLE;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign cnt_lo = result[7:0];
   assign cnt_hi = result[15:8];

   // R2
   trig_clear_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      trig_bit |=> !trig_bit);

   // R8
   busy_ignore_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (busy && trig_we) |=> !trig_bit);

   // R9
   busy_done_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      !(busy && done));

   // R4
   unused_zero_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == ST_IDLE && trig_bit && src_dec == SRC_NONE)
         |=> (done && !busy && cnt_lo == 8'h00 && cnt_hi == 8'h00));

   // R7
   result_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == ST_GATE) |=> $stable(result));

   // R5
   gate_len_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (state == ST_GATE) |-> (tmr < gate_len_q));
endmodule

// File: tb/freq_gate_counter_tb.sv
`timescale 1ns/1ps
module freq_gate_counter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int T_IF       = 6;
   localparam int T_PRE      = 14;
   localparam int T_F0       = 2;
   localparam int G0 = 100, G1 = 200, G2 = 800, G3 = 14000;
   localparam int DRAIN = 16;
   localparam int TOL   = 3;

   logic       ref_clk = 1'b0;
   logic       ref_rst_n = 1'b0;
   logic       src_if = 1'b0, src_presc = 1'b0, src_f0 = 1'b0;
   logic [2:0] src_code = '0;
   logic [1:0] gate_code = '0;
   logic       trig_we = 1'b0, trig_wdata = 1'b0;
   logic       trig_bit, busy, done;
   logic [7:0] cnt_lo, cnt_hi;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
   always #(T_IF/2)  src_if    = ~src_if;
   always #(T_PRE/2) src_presc = ~src_presc;
   always #(T_F0/2)  src_f0    = ~src_f0;

   freq_gate_counter #(
      .GATE_CYC0(G0), .GATE_CYC1(G1), .GATE_CYC2(G2), .GATE_CYC3(G3),
      .DRAIN_CYC(DRAIN)
   ) dut_i (
      .ref_clk(ref_clk), .ref_rst_n(ref_rst_n),
      .src_if(src_if), .src_presc(src_presc), .src_f0(src_f0),
      .src_code(src_code), .gate_code(gate_code),
      .trig_we(trig_we), .trig_wdata(trig_wdata),
      .trig_bit(trig_bit), .busy(busy), .done(done),
      .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int result_now();
      return {cnt_hi, cnt_lo};
   endfunction

   function automatic int gate_len(input int gs);
      case (gs)
         0: return G0;
         1: return G1;
         2: return G2;
         default: return G3;
      endcase
   endfunction

   function automatic int src_period(input int code);
      case (code)
         1, 7: return T_IF;
         2:    return T_PRE;
         4, 5: return T_F0;
         default: return 0;
      endcase
   endfunction

   task automatic measure(input int code, input int gs);
      int g, tp, exp, prev, n, res, diff;
      g    = gate_len(gs);
      tp   = src_period(code);
      prev = result_now();
      @(negedge ref_clk);
      src_code = 3'(code); gate_code = 2'(gs);
      trig_we = 1'b1; trig_wdata = 1'b1;
      @(negedge ref_clk);
      trig_we = 1'b0;
      check(trig_bit == 1'b1, "R2 start bit set", int'(trig_bit), 1);
      @(negedge ref_clk);
      check(trig_bit == 1'b0, "R2 start bit self-clear", int'(trig_bit), 0);
      if (tp == 0) begin
         check(busy == 1'b0, "R4 unused code no busy", int'(busy), 0);
         check(done == 1'b1, "R4 unused code done", int'(done), 1);
         check(result_now() == 0, "R4 unused code zero", result_now(), 0);
         return;
      end
      n = 0;
      while (busy && n < 20000) begin
         n++;
         if (n == 5) begin
            check(result_now() == prev, "R7 result held during run", result_now(), prev);
            check(done == 1'b0, "R9 done low while busy", int'(done), 0);
         end
         if (n == 10) begin
            trig_we = 1'b1; trig_wdata = 1'b1;
         end
         if (n == 11) begin
            trig_we = 1'b0;
            check(trig_bit == 1'b0, "R8 trigger ignored while busy", int'(trig_bit), 0);
         end
         @(negedge ref_clk);
      end
      check(n == g + DRAIN, "R5 R8 busy length", n, g + DRAIN);
      check(done == 1'b1, "R9 done after capture", int'(done), 1);
      exp = (g * CLK_PERIOD) / tp;
      res = result_now();
      if (exp > 65535 + TOL) begin
         check(res == 65535, "R6 saturation", res, 65535);
      end else begin
         if (exp > 65535) exp = 65535;
         diff = res - exp;
         if (diff < 0) diff = -diff;
         check(diff <= TOL, "R3 R5 edge count", res, exp);
      end
      check(cnt_lo == 8'(res) && cnt_hi == 8'(res >> 8), "R7 byte split", {cnt_hi, cnt_lo}, res);
   endtask

   initial begin
      repeat (5000) @(posedge ref_clk);
      repeat (185000) @(posedge ref_clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge ref_clk);
      ref_rst_n = 1'b1;
      @(negedge ref_clk);
      // R1
      check(trig_bit == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset flags",
            {29'd0, trig_bit, busy, done}, 0);
      check(result_now() == 0, "R1 reset count", result_now(), 0);
      // R2: writing 0 does nothing
      trig_we = 1'b1; trig_wdata = 1'b0;
      @(negedge ref_clk);
      trig_we = 1'b0;
      check(trig_bit == 1'b0, "R2 write of zero", int'(trig_bit), 0);
      @(negedge ref_clk);
      check(busy == 1'b0 && done == 1'b0, "R2 write of zero no effect",
            {30'd0, busy, done}, 0);
      for (int gs = 0; gs < 4; gs++) begin
         for (int code = 0; code < 8; code++) begin
            measure(code, gs);
         end
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule